// File: doc/BRIEF.md
# Process-Tagged Fully Associative Translation Buffer

This block caches virtual-to-physical page translations for a machine with 32-bit virtual addresses, 1 KiB pages and 30-bit physical addresses. Every entry holds a valid flag, the owning process identifier, a 22-bit virtual page number and a 20-bit physical frame number. A lookup compares the requesting process and page number against all entries at once and answers in the same cycle with hit, miss and the translated address.

The operating-system side installs translations through a fill port and removes them through two flush controls: one drops every entry that belongs to a given process, and one empties the whole buffer. Each entry carries its process tag, so translations of several processes stay resident side by side and a context switch does not need a flush. A fill picks its slot in a fixed order. It first uses an entry already holding the same process and page. If there is none, it uses the lowest-numbered free entry. If every entry is full, it uses a rotating victim pointer.

Top module: `ptag_tlb`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports lk_hit=0, lk_miss=1 and lk_paddr=0 until a fill is made.
- R2: The lookup is combinational. On a hit, lk_paddr equals the stored 20-bit frame number in bits 29:10, placed above the request's unchanged offset lk_vaddr[9:0]. The page number compared is lk_vaddr[31:10]. A filled translation is visible from the cycle after its fill edge.
- R3: A hit needs both the stored process ID to equal lk_pid and the stored page number to match. The same page requested under another process ID misses.
- R4: On a miss, lk_hit=0, lk_miss=1 and lk_paddr is all zeros.
- R5: A fill with no matching resident entry writes into the lowest-numbered invalid entry and leaves the victim pointer unchanged.
- R6: A fill whose process ID and page number match a valid entry overwrites that entry's frame in place. No other entry is evicted, and at most one entry ever matches a lookup.
- R7: When all entries are valid and the fill has no match, the fill replaces the entry at the victim pointer. The pointer starts at entry 0 after reset and advances by one, wrapping, only on such an eviction.
- R8: A pulse of flush_pid_en invalidates, on one clock edge, every entry tagged with flush_pid. Entries of other processes stay intact.
- R9: flush_all invalidates every entry on one clock edge, and a fill requested in the same cycle is discarded.
- R10: A lookup made in the same cycle as a fill sees the contents from before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_pid | input | 8 | Process ID of the requester |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Translation not found |
| lk_paddr | output | 30 | Physical address, zero on miss |
| fill_en | input | 1 | Install a translation on this edge |
| fill_pid | input | 8 | Process ID of the new translation |
| fill_vpn | input | 22 | Virtual page number of the new translation |
| fill_pfn | input | 20 | Physical frame number of the new translation |
| flush_pid_en | input | 1 | Invalidate all entries of flush_pid |
| flush_pid | input | 8 | Process ID to flush |
| flush_all | input | 1 | Invalidate every entry |

## Verification
The hardest cases to reach from the ports are the slot choices. These are round-robin eviction when the buffer is full, the return to lowest-free-slot allocation after a per-process flush has opened holes, and the check that an in-place overwrite does not move the victim pointer. None of these is visible directly. The stimulus fills all sixteen entries with arithmetically derived pages and frames. It then forces evictions, overwrites and flushes in a planned order and watches which older translations start missing and which keep hitting. This shows which slot each fill took. Same-cycle fill and lookup, and fill discarded by flush_all, are driven in the same cycle and checked on both sides of the edge.

// File: rtl/ptag_tlb_pkg.sv
package ptag_tlb_pkg;
  localparam int DEF_VA_W    = 32;
  localparam int DEF_OFF_W   = 10;
  localparam int DEF_PFN_W   = 20;
  localparam int DEF_PID_W   = 8;
  localparam int DEF_ENTRIES = 16;
endpackage

// File: rtl/tlb_key_cmp.sv
module tlb_key_cmp #(
  parameter int N  = 16,
  parameter int KW = 30
) (
  input  logic [N-1:0]         vld,
  input  logic [N-1:0][KW-1:0] keys,
  input  logic [KW-1:0]        probe,
  output logic [N-1:0]         match
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = vld[i] && (keys[i] == probe);
  end
endmodule

// File: rtl/tlb_slot_pick.sv
module tlb_slot_pick #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  vld,
  input  logic [N-1:0]  same,
  input  logic          advance,
  output logic [IW-1:0] slot
);
  logic [IW-1:0] ptr;
  logic [IW-1:0] free_idx, same_idx;
  logic          free_any, same_any;

  always_comb begin
    free_idx = '0;
    free_any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_idx = IW'(i);
        free_any = 1'b1;
      end
    end
  end

  always_comb begin
    same_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (same[i]) same_idx = same_idx | IW'(i);
    end
    same_any = |same;
  end

  always_comb begin
    if (same_any)      slot = same_idx;
    else if (free_any) slot = free_idx;
    else               slot = ptr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (advance && !same_any && !free_any) begin
      ptr <= (ptr == IW'(N - 1)) ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/ptag_tlb.sv
module ptag_tlb
  import ptag_tlb_pkg::*;
#(
  parameter int VA_W    = DEF_VA_W,
  parameter int OFF_W   = DEF_OFF_W,
  parameter int PFN_W   = DEF_PFN_W,
  parameter int PID_W   = DEF_PID_W,
  parameter int ENTRIES = DEF_ENTRIES,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PA_W   = PFN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic [PID_W-1:0] lk_pid,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PA_W-1:0]  lk_paddr,
  input  logic             fill_en,
  input  logic [PID_W-1:0] fill_pid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             flush_pid_en,
  input  logic [PID_W-1:0] flush_pid,
  input  logic             flush_all
);
  localparam int TAG_W = PID_W + VPN_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]             ent_vld;
  logic [ENTRIES-1:0][TAG_W-1:0]  ent_tag;
  logic [ENTRIES-1:0][PFN_W-1:0]  ent_pfn;

  logic [TAG_W-1:0]   lk_key, fill_key;
  logic [ENTRIES-1:0] lk_vec, fl_vec, fp_vec;
  logic [PFN_W-1:0]   pfn_sel;
  logic [IDX_W-1:0]   pick;
  logic               fill_go;

  assign lk_key   = {lk_pid, lk_vaddr[VA_W-1:OFF_W]};
  assign fill_key = {fill_pid, fill_vpn};
  assign fill_go  = fill_en && !flush_all;

  tlb_key_cmp #(.N(ENTRIES), .KW(TAG_W)) u_lk_cmp (
    .vld(ent_vld), .keys(ent_tag), .probe(lk_key), .match(lk_vec)
  );

  tlb_key_cmp #(.N(ENTRIES), .KW(TAG_W)) u_fill_cmp (
    .vld(ent_vld), .keys(ent_tag), .probe(fill_key), .match(fl_vec)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_fpid
    assign fp_vec[i] = (ent_tag[i][TAG_W-1 -: PID_W] == flush_pid);
  end

  tlb_slot_pick #(.N(ENTRIES), .IW(IDX_W)) u_pick (
    .clk(clk), .rst(rst), .vld(ent_vld), .same(fl_vec),
    .advance(fill_go), .slot(pick)
  );

  always_comb begin
    pfn_sel = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_vec[i]) pfn_sel = pfn_sel | ent_pfn[i];
    end
  end

  assign lk_hit   = |lk_vec;
  assign lk_miss  = ~lk_hit;
  assign lk_paddr = lk_hit ? {pfn_sel, lk_vaddr[OFF_W-1:0]} : '0;

  always_ff @(posedge clk) begin
    if (rst || flush_all) begin
      ent_vld <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (flush_pid_en && fp_vec[i]) ent_vld[i] <= 1'b0;
      end
      if (fill_go) ent_vld[pick] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      ent_tag[pick] <= fill_key;
      ent_pfn[pick] <= fill_pfn;
    end
  end
endmodule

// File: rtl/ptag_tlb_chk.sv
module ptag_tlb_chk #(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 10,
  parameter int PFN_W   = 20,
  parameter int PID_W   = 8,
  parameter int ENTRIES = 16,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PA_W   = PFN_W + OFF_W
) (
  input logic               clk,
  input logic               rst,
  input logic [VA_W-1:0]    lk_vaddr,
  input logic [PID_W-1:0]   lk_pid,
  input logic               lk_hit,
  input logic               lk_miss,
  input logic [PA_W-1:0]    lk_paddr,
  input logic               fill_en,
  input logic [PID_W-1:0]   fill_pid,
  input logic [VPN_W-1:0]   fill_vpn,
  input logic [PFN_W-1:0]   fill_pfn,
  input logic               flush_pid_en,
  input logic [PID_W-1:0]   flush_pid,
  input logic               flush_all,
  input logic [ENTRIES-1:0] ent_vld,
  input logic [ENTRIES-1:0] lk_vec
);
  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ent_vld == '0));

  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0] && !lk_miss));

  assert_fill_visible_R2: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !flush_all) |=>
      ((lk_pid == $past(fill_pid) && lk_vaddr[VA_W-1:OFF_W] == $past(fill_vpn))
        |-> (lk_hit && lk_paddr[PA_W-1:OFF_W] == $past(fill_pfn))));

  assert_miss_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_miss && lk_paddr == '0));

  assert_single_match_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_vec));

  assert_pid_flushed_R8: assert property (@(posedge clk) disable iff (rst)
    (flush_pid_en && !fill_en && !flush_all) |=>
      ((lk_pid == $past(flush_pid)) |-> !lk_hit));

  assert_flush_all_R9: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> (ent_vld == '0));
endmodule

bind ptag_tlb ptag_tlb_chk #(
  .VA_W(VA_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .PID_W(PID_W), .ENTRIES(ENTRIES)
) u_chk (.*);

// File: tb/tb_ptag_tlb.sv
`timescale 1ns/1ps
module tb_ptag_tlb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_pid = '0;
  logic        lk_hit, lk_miss;
  logic [29:0] lk_paddr;
  logic        fill_en = 1'b0;
  logic [7:0]  fill_pid = '0;
  logic [21:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic        flush_pid_en = 1'b0;
  logic [7:0]  flush_pid = '0;
  logic        flush_all = 1'b0;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  ptag_tlb dut (
    .clk(clk), .rst(rst), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
    .fill_en(fill_en), .fill_pid(fill_pid), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .flush_pid_en(flush_pid_en), .flush_pid(flush_pid),
    .flush_all(flush_all)
  );

  function automatic logic [21:0] vpn_of(int i);
    return 22'(i * 37 + 5);
  endfunction

  function automatic logic [19:0] pfn_of(int i);
    return 20'(i * 1001 + 3);
  endfunction

  task automatic probe(input logic [7:0] pid, input logic [21:0] vpn,
                       input logic [9:0] off, input bit eh,
                       input logic [19:0] epfn, input string req);
    logic [29:0] epa;
    epa = eh ? {epfn, off} : 30'd0;
    lk_pid   = pid;
    lk_vaddr = {vpn, off};
    #1;
    n_chk++;
    if (lk_hit !== eh || lk_miss !== !eh || lk_paddr !== epa) begin
      n_err++;
      $display("FAIL %s: hit=%0b miss=%0b pa=%h expected hit=%0b pa=%h",
               req, lk_hit, lk_miss, lk_paddr, eh, epa);
    end
  endtask

  task automatic chk(input logic [7:0] pid, input logic [21:0] vpn,
                     input logic [9:0] off, input bit eh,
                     input logic [19:0] epfn, input string req);
    @(negedge clk);
    probe(pid, vpn, off, eh, epfn, req);
  endtask

  task automatic do_fill(input logic [7:0] pid, input logic [21:0] vpn,
                         input logic [19:0] pfn);
    @(negedge clk);
    fill_pid = pid; fill_vpn = vpn; fill_pfn = pfn; fill_en = 1'b1;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  initial begin
    #800000;
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: empty after reset
    chk(8'd1, vpn_of(0), 10'd0, 1'b0, 20'd0, "R1");
    chk(8'd0, 22'd0, 10'd0, 1'b0, 20'd0, "R1");

    for (int i = 0; i < 16; i++) do_fill(8'd1, vpn_of(i), pfn_of(i));

    // R2: every entry translates with several offsets
    for (int i = 0; i < 16; i++) begin
      chk(8'd1, vpn_of(i), 10'd0, 1'b1, pfn_of(i), "R2");
      chk(8'd1, vpn_of(i), 10'h3FF, 1'b1, pfn_of(i), "R2");
      chk(8'd1, vpn_of(i), 10'(i * 61 + 7), 1'b1, pfn_of(i), "R2");
    end
    // R3: other process misses the same pages
    for (int i = 0; i < 16; i += 3)
      chk(8'd2, vpn_of(i), 10'd5, 1'b0, 20'd0, "R3");
    // R4: unmapped page
    chk(8'd1, 22'd3, 10'd9, 1'b0, 20'd0, "R4");
    chk(8'd1, 22'h3FFFFF, 10'h3FF, 1'b0, 20'd0, "R4");

    // R7: full buffer, pointer evicts slot 0 then 1
    do_fill(8'd2, vpn_of(0), 20'hABCDE);
    chk(8'd2, vpn_of(0), 10'd1, 1'b1, 20'hABCDE, "R7");
    chk(8'd1, vpn_of(0), 10'd1, 1'b0, 20'd0, "R7");
    chk(8'd1, vpn_of(1), 10'd1, 1'b1, pfn_of(1), "R7");
    do_fill(8'd2, 22'd900, 20'h11111);
    chk(8'd2, 22'd900, 10'd2, 1'b1, 20'h11111, "R7");
    chk(8'd1, vpn_of(1), 10'd2, 1'b0, 20'd0, "R7");

    // R6: overwrite in place, nothing evicted
    do_fill(8'd1, vpn_of(2), 20'h22222);
    chk(8'd1, vpn_of(2), 10'd3, 1'b1, 20'h22222, "R6");
    chk(8'd1, vpn_of(3), 10'd3, 1'b1, pfn_of(3), "R6");
    chk(8'd1, vpn_of(15), 10'd3, 1'b1, pfn_of(15), "R6");

    // R7: pointer untouched by overwrite, now evicts slot 2
    do_fill(8'd1, 22'd1000, 20'h33333);
    chk(8'd1, vpn_of(2), 10'd4, 1'b0, 20'd0, "R7");
    chk(8'd1, vpn_of(3), 10'd4, 1'b1, pfn_of(3), "R7");
    chk(8'd1, 22'd1000, 10'd4, 1'b1, 20'h33333, "R7");

    // R10: lookup in the fill cycle sees old contents (evicts slot 3)
    @(negedge clk);
    fill_pid = 8'd1; fill_vpn = 22'd1001; fill_pfn = 20'h44444; fill_en = 1'b1;
    probe(8'd1, 22'd1001, 10'd8, 1'b0, 20'd0, "R10");
    @(negedge clk);
    fill_en = 1'b0;
    probe(8'd1, 22'd1001, 10'd8, 1'b1, 20'h44444, "R10");
    chk(8'd1, vpn_of(3), 10'd8, 1'b0, 20'd0, "R7");

    // R8: flush process 2 only
    @(negedge clk);
    flush_pid = 8'd2; flush_pid_en = 1'b1;
    @(negedge clk);
    flush_pid_en = 1'b0;
    chk(8'd2, vpn_of(0), 10'd1, 1'b0, 20'd0, "R8");
    chk(8'd2, 22'd900, 10'd1, 1'b0, 20'd0, "R8");
    chk(8'd1, vpn_of(4), 10'd1, 1'b1, pfn_of(4), "R8");
    chk(8'd1, 22'd1000, 10'd1, 1'b1, 20'h33333, "R8");

    // R5: holes at slots 0 and 1 are reused before the pointer (at 4)
    do_fill(8'd1, 22'd1100, 20'h55555);
    chk(8'd1, vpn_of(4), 10'd6, 1'b1, pfn_of(4), "R5");
    do_fill(8'd1, 22'd1101, 20'h66666);
    chk(8'd1, vpn_of(4), 10'd6, 1'b1, pfn_of(4), "R5");
    chk(8'd1, 22'd1100, 10'd6, 1'b1, 20'h55555, "R5");
    chk(8'd1, 22'd1101, 10'd6, 1'b1, 20'h66666, "R5");
    do_fill(8'd1, 22'd1102, 20'h77777);
    chk(8'd1, vpn_of(4), 10'd6, 1'b0, 20'd0, "R7");
    chk(8'd1, vpn_of(5), 10'd6, 1'b1, pfn_of(5), "R7");
    chk(8'd1, 22'd1102, 10'd6, 1'b1, 20'h77777, "R7");

    // R9: flush_all discards a same-cycle fill
    @(negedge clk);
    flush_all = 1'b1;
    fill_pid = 8'd1; fill_vpn = 22'd1200; fill_pfn = 20'h88888; fill_en = 1'b1;
    @(negedge clk);
    flush_all = 1'b0; fill_en = 1'b0;
    chk(8'd1, 22'd1200, 10'd0, 1'b0, 20'd0, "R9");
    chk(8'd1, vpn_of(5), 10'd0, 1'b0, 20'd0, "R9");
    chk(8'd1, 22'd1100, 10'd0, 1'b0, 20'd0, "R9");
    chk(8'd1, 22'd1001, 10'd0, 1'b0, 20'd0, "R9");

    do_fill(8'd7, 22'd42, 20'hFFFFF);
    chk(8'd7, 22'd42, 10'h3FF, 1'b1, 20'hFFFFF, "R2");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule